// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides whether a processor core should take an interrupt trap. Two request vectors, one from software and one from external sources, share a single level space. Software request bit i, within a configurable window, stands for level i minus the window base plus one. External request bit i, within its own window, stands for level i directly. When an evaluation runs, the block forms a summary mask of every in-window pending bit. It picks the winning level: the highest external level if any external request is pending, otherwise the highest software level. It takes the interrupt only when that level is nonzero and strictly above the current priority level.

An evaluation must first be requested by a pulse on `chk_post`. It then waits until the program counter is outside privileged mode and the core is not finishing a fetch-miss stall. When an interrupt is taken, the summary and winning level are captured into output registers and a one-cycle trap pulse is raised. A nonzero asynchronous-trap request seen at evaluation time is unsupported. It parks the block in an error state until reset.

The controller has four states:
- ST_IDLE: nothing pending. A post moves it to ST_ARMED.
- ST_ARMED: an evaluation is pending and waits while ineligible. When eligible it evaluates and moves to one of three states:
  - ST_HALT on an asynchronous-trap request;
  - ST_TRAP when the interrupt is taken;
  - ST_IDLE otherwise.
- ST_TRAP: drives the trap pulse for one cycle, then returns to ST_ARMED if a new post arrived, else to ST_IDLE.
- ST_HALT: terminal until reset.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset `trap`, `isr_summary`, `int_id` and `ast_err` are all zero.
- R2: With defaults, each software request bit i for 1 <= i <= 15 gives candidate level i and sets summary bit i. Software bit 0 and bits 16..31 contribute nothing.
- R3: With defaults, each external request bit i for 16 <= i <= 31 gives candidate level i and sets summary bit i. External bits 0..15 contribute nothing.
- R4: The winning level is the highest pending external level if any external request is in window, otherwise the highest pending software level, otherwise 0.
- R5: An interrupt is taken only if the winning level is nonzero and strictly greater than `cur_ipl`. Equal or lower does not trap.
- R6: An evaluation happens at the clock edge ending an ST_ARMED cycle. If the interrupt is taken, `isr_summary` and `int_id` are written at that edge and `trap` is high for exactly the following cycle.
- R7: An evaluation that does not take an interrupt leaves `isr_summary` and `int_id` unchanged and raises no trap.
- R8: A pending evaluation waits while `pc_priv` is 1 or `stall_done` is 1, and it runs at the first edge where both are 0.
- R9: Each evaluation clears the pending check, whether or not it traps. Later request changes cause no trap until a new `chk_post` pulse. A post in the evaluating cycle is absorbed by that evaluation.
- R10: A nonzero `ast_req` at evaluation time sets `ast_err` permanently until reset. That evaluation raises no trap and leaves the output registers unchanged, and no further evaluations or traps occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_post | input | 1 | Pulse requesting an evaluation |
| sw_req | input | 32 | Software request vector |
| ext_req | input | 32 | External request vector |
| cur_ipl | input | 5 | Current interrupt priority level |
| pc_priv | input | 1 | Program-counter privileged-mode bit (bit 0 of PC) |
| stall_done | input | 1 | Core is in the fetch-miss-complete stall state |
| ast_req | input | 4 | Asynchronous-trap request value |
| trap | output | 1 | One-cycle trap pulse |
| isr_summary | output | 32 | Captured summary mask of pending sources |
| int_id | output | 5 | Captured winning interrupt level |
| ast_err | output | 1 | Sticky unsupported-condition flag |

## Verification
A wrong controller state is visible within two cycles of a post. A lost ST_ARMED state shows up as a missing trap after eligibility returns. A stuck ST_TRAP state shows up as a trap wider than one cycle. A missed exit from ST_HALT shows up as a trap after `ast_err` rose. A wrong scan order or window offset shows up as a wrong `int_id` or `isr_summary` in the cycle the trap is high. A wrong compare shows up as a trap at equal priority or a missing trap one level above it.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRAP  = 2'd2,
        ST_HALT  = 2'd3
    } evl_state_e;
endpackage

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
    parameter int REQ_W   = 32,
    parameter int LVL_W   = 5,
    parameter int SW_MIN  = 1,
    parameter int SW_MAX  = 16,
    parameter int EXT_MIN = 16,
    parameter int EXT_MAX = 32
) (
    input  logic [REQ_W-1:0] sw_req,
    input  logic [REQ_W-1:0] ext_req,
    output logic [REQ_W-1:0] summary,
    output logic [LVL_W-1:0] level
);
    logic [REQ_W-1:0] sw_win;
    logic [REQ_W-1:0] ext_win;

    // window masks built per bit
    for (genvar g = 0; g < REQ_W; g++) begin : g_win
        localparam bit SW_IN  = (g >= SW_MIN) && (g < SW_MAX);
        localparam bit EXT_IN = (g >= EXT_MIN) && (g < EXT_MAX);
        assign sw_win[g]  = SW_IN;
        assign ext_win[g] = EXT_IN;
    end

    logic [REQ_W-1:0] sw_hit;
    logic [REQ_W-1:0] ext_hit;
    assign sw_hit  = sw_req & sw_win;
    assign ext_hit = ext_req & ext_win;
    assign summary = sw_hit | ext_hit;

    // ascending scan, software first then external; last hit wins
    always_comb begin
        level = '0;
        for (int i = 0; i < REQ_W; i++) begin
            if (sw_hit[i]) level = LVL_W'(i - SW_MIN + 1);
        end
        for (int i = 0; i < REQ_W; i++) begin
            if (ext_hit[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_eval_fsm.sv
module irq_eval_fsm
    import irq_lvl_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post,
    input  logic             pc_priv,
    input  logic             stall_done,
    input  logic             ast_bad,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] cur_ipl,
    output logic             commit,
    output logic             trap,
    output logic             halted
);
    evl_state_e state_q, state_d;
    logic eligible;
    logic take;

    assign eligible = !pc_priv && !stall_done;
    assign take     = (level != '0) && (level > cur_ipl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (post) state_d = ST_ARMED;
            ST_ARMED: begin
                if (eligible) begin
                    if (ast_bad)   state_d = ST_HALT;
                    else if (take) state_d = ST_TRAP;
                    else           state_d = ST_IDLE;
                end
            end
            ST_TRAP:  state_d = post ? ST_ARMED : ST_IDLE;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        trap   = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_ARMED: commit = eligible && !ast_bad && take;
            ST_TRAP:  trap   = 1'b1;
            ST_HALT:  halted = 1'b1;
            default:  ;
        endcase
    end

    // R8
    eval_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP) |-> ($past(state_q) == ST_ARMED) && !$past(pc_priv) && !$past(stall_done));
    // R6
    trap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);
    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !trap));
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int REQ_W = 32,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [REQ_W-1:0] summary_in,
    input  logic [LVL_W-1:0] level_in,
    output logic [REQ_W-1:0] summary_q,
    output logic [LVL_W-1:0] level_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            summary_q <= '0;
            level_q   <= '0;
        end else if (commit) begin
            summary_q <= summary_in;
            level_q   <= level_in;
        end
    end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
    parameter int REQ_W   = 32,
    parameter int LVL_W   = 5,
    parameter int AST_W   = 4,
    parameter int SW_MIN  = 1,
    parameter int SW_MAX  = 16,
    parameter int EXT_MIN = 16,
    parameter int EXT_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_post,
    input  logic [REQ_W-1:0] sw_req,
    input  logic [REQ_W-1:0] ext_req,
    input  logic [LVL_W-1:0] cur_ipl,
    input  logic             pc_priv,
    input  logic             stall_done,
    input  logic [AST_W-1:0] ast_req,
    output logic             trap,
    output logic [REQ_W-1:0] isr_summary,
    output logic [LVL_W-1:0] int_id,
    output logic             ast_err
);
    logic [REQ_W-1:0] scan_sum;
    logic [LVL_W-1:0] scan_lvl;
    logic             commit;
    logic             ast_bad;

    assign ast_bad = |ast_req;

    irq_level_scan #(
        .REQ_W(REQ_W), .LVL_W(LVL_W),
        .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
        .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
    ) u_scan (
        .sw_req (sw_req),
        .ext_req(ext_req),
        .summary(scan_sum),
        .level  (scan_lvl)
    );

    irq_eval_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (chk_post),
        .pc_priv   (pc_priv),
        .stall_done(stall_done),
        .ast_bad   (ast_bad),
        .level     (scan_lvl),
        .cur_ipl   (cur_ipl),
        .commit    (commit),
        .trap      (trap),
        .halted    (ast_err)
    );

    irq_capture #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .summary_in(scan_sum),
        .level_in  (scan_lvl),
        .summary_q (isr_summary),
        .level_q   (int_id)
    );

    // R5
    level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (int_id != '0) && (int_id > $past(cur_ipl)));
    // R7
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> $stable(int_id) && $stable(isr_summary));
    // R2
    summary_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ((isr_summary & ~($past(sw_req) | $past(ext_req))) == '0));
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
    localparam int REQ_W = 32;
    localparam int LVL_W = 5;
    localparam int AST_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chk_post = 1'b0;
    logic [REQ_W-1:0] sw_req = '0;
    logic [REQ_W-1:0] ext_req = '0;
    logic [LVL_W-1:0] cur_ipl = '0;
    logic             pc_priv = 1'b0;
    logic             stall_done = 1'b0;
    logic [AST_W-1:0] ast_req = '0;
    logic             trap;
    logic [REQ_W-1:0] isr_summary;
    logic [LVL_W-1:0] int_id;
    logic             ast_err;

    always #4 clk = ~clk;

    irq_level_arbiter u_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .chk_post(chk_post),
        .sw_req(sw_req), .ext_req(ext_req), .cur_ipl(cur_ipl),
        .pc_priv(pc_priv), .stall_done(stall_done), .ast_req(ast_req),
        .trap(trap), .isr_summary(isr_summary), .int_id(int_id), .ast_err(ast_err)
    );

    typedef struct packed {
        logic [REQ_W-1:0] sum;
        logic [LVL_W-1:0] id;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic [REQ_W-1:0] last_sum = '0;
    logic [LVL_W-1:0] last_id = '0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per observed trap
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && trap) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected trap", 1, 0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    check("R6 captured summary", isr_summary, x.sum);
                    check("R6 captured level", int_id, x.id);
                end
            end
        end
    end

    // driver: one post followed by the evaluation cycle
    task automatic run_case(input string tag, input logic [REQ_W-1:0] s, input logic [REQ_W-1:0] e,
                            input logic [LVL_W-1:0] ipl, input bit take,
                            input logic [REQ_W-1:0] xs, input logic [LVL_W-1:0] xi);
        sw_req = s; ext_req = e; cur_ipl = ipl; chk_post = 1'b1;
        if (take) exp_q.push_back(exp_t'{sum: xs, id: xi});
        @(negedge clk);
        chk_post = 1'b0;
        @(negedge clk);
        check({tag, " trap"}, trap, take);
        if (take) begin
            last_sum = xs; last_id = xi;
        end else begin
            check({tag, " summary held"}, isr_summary, last_sum);
            check({tag, " level held"}, int_id, last_id);
        end
        @(negedge clk);
        check({tag, " trap one cycle"}, trap, 0);
    endtask

    initial begin
        #(8 * 20000);
        check("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 trap", trap, 0);
        check("R1 summary", isr_summary, 0);
        check("R1 level", int_id, 0);
        check("R1 err", ast_err, 0);

        // R2 single software bit 3 -> level 3
        run_case("R2 sw bit3", 32'h8, 32'h0, 5'd0, 1, 32'h8, 5'd3);
        // R2 R4 highest software wins (5 and 12)
        run_case("R4 sw 5+12", 32'h1020, 32'h0, 5'd2, 1, 32'h1020, 5'd12);
        // R3 R4 external 20 beats software 15
        run_case("R4 ext20 over sw15", 32'h8000, 32'h0010_0000, 5'd0, 1, 32'h0010_8000, 5'd20);
        // R3 highest external wins (17 and 30)
        run_case("R3 ext 17+30", 32'h0, 32'h4002_0000, 5'd10, 1, 32'h4002_0000, 5'd30);
        // R5 R7 equal priority does not trap
        run_case("R5 equal ipl", 32'h80, 32'h0, 5'd7, 0, 32'h0, 5'd0);
        // R5 one above traps
        run_case("R5 one above", 32'h100, 32'h0, 5'd7, 1, 32'h100, 5'd8);
        // R2 R3 out-of-window bits contribute nothing -> level 0, no trap
        run_case("R3 out of window", 32'h0010_0001, 32'h0000_0008, 5'd0, 0, 32'h0, 5'd0);

        // R9 no evaluation without a new post
        sw_req = 32'h4000; cur_ipl = 5'd0;
        repeat (4) begin
            @(negedge clk);
            check("R9 no post no trap", trap, 0);
        end
        check("R9 level untouched", int_id, last_id);

        // R8 privileged-mode hold
        pc_priv = 1'b1; sw_req = 32'h200; chk_post = 1'b1;
        @(negedge clk);
        chk_post = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R8 priv wait", trap, 0);
        end
        exp_q.push_back(exp_t'{sum: 32'h200, id: 5'd9});
        pc_priv = 1'b0;
        @(negedge clk);
        check("R8 priv released trap", trap, 1);
        last_sum = 32'h200; last_id = 5'd9;
        @(negedge clk);

        // R8 stall-complete hold
        stall_done = 1'b1; ext_req = 32'h0100_0000; chk_post = 1'b1;
        @(negedge clk);
        chk_post = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R8 stall wait", trap, 0);
        end
        exp_q.push_back(exp_t'{sum: 32'h0100_0200, id: 5'd24});
        stall_done = 1'b0;
        @(negedge clk);
        check("R8 stall released trap", trap, 1);
        last_sum = 32'h0100_0200; last_id = 5'd24;
        @(negedge clk);
        ext_req = '0;

        // R10 asynchronous-trap request -> sticky error, no trap
        ast_req = 4'd3;
        run_case("R10 ast", 32'h10, 32'h0, 5'd0, 0, 32'h0, 5'd0);
        check("R10 err set", ast_err, 1);
        ast_req = 4'd0;
        chk_post = 1'b1;
        @(negedge clk);
        chk_post = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R10 no trap after halt", trap, 0);
        end
        check("R10 err sticky", ast_err, 1);
        check("R10 level held", int_id, last_id);
        check("R6 queue drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule